// File: doc/BRIEF.md
# Predicated Segment Load with Vector Broadcast

This unit carries out one vector load that builds a 256-bit segment of eight 32-bit lanes and then copies that segment into every 256-bit slice of a destination vector. The vector width is a parameter. A single-cycle start pulse supplies a base address, a word index and a lane predicate. From these the unit forms a start address, reads one word over a request/response memory port for each lane whose predicate bit is set, and writes zero to every other lane without any memory access.

Once all active lanes have returned data, the unit loads the assembled segment into each slice of its destination output and pulses a done flag. An error response on a read ends the operation early. In that case the unit raises a fault flag with the lane number and leaves the destination as it was. A vector width too narrow to hold one segment is treated as an illegal configuration. Such a start sets an illegal flag and completes at once, with no memory traffic.

Top module: `seg_bcast_load`

## Requirements
- R1: The start address is base_addr plus index multiplied by four, with the sum taken modulo 2^AW. The read for lane k (0 to 7) goes to the start address plus 4*k.
- R2: A lane whose bit in pred[7:0] is 0 reads as zero in the result, and no request is issued for it. The number of requests in an operation equals the number of set bits in pred[7:0].
- R3: Reads go out in ascending lane order, and only one request is outstanding at a time. While req_valid is high and req_ready is low, req_valid stays high and req_addr holds its value.
- R4: On success, every 256-bit slice j of vdst (bits 256*j+255 down to 256*j) holds the segment, with lane k in bits 32*k+31 down to 32*k of the slice. Predicate bits above bit 7 have no effect.
- R5: With pred[7:0] equal to zero, done is high in the second cycle after the cycle in which start is sampled. At that point vdst is all zeros and no request has been issued.
- R6: An error response (rsp_err high with rsp_valid) ends the operation. done is pulsed, fault goes high, fault_lane gives the lane that failed, no further requests are issued, and vdst is left unchanged.
- R7: When VLEN is below 256 (for example 128), a start sets illegal and pulses done in the next cycle. busy and req_valid stay low, and vdst is left unchanged.
- R8: done is high for exactly one cycle per operation. A start that arrives while busy is high is ignored.
- R9: After reset, busy, done, req_valid, fault and illegal are low, and vdst is zero.
- R10: fault and illegal hold their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only when idle |
| base_addr | input | AW | Byte base address |
| index | input | IW | Word index added to the base |
| pred | input | PRED_W | Lane predicate; only bits 7:0 are used |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Byte address of the requested word |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response word |
| rsp_err | input | 1 | Read response carries an error |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last start hit an unsupported vector width |
| fault | output | 1 | Last operation ended on an error response |
| fault_lane | output | 3 | Lane whose read failed |
| vdst | output | VLEN | Destination vector |

## Verification
The bench goes after the following corner cases:
- Addresses that wrap past the top of the address space and an index of minus two. A unit that did not scale the index by four, or that kept a carry, would read the wrong words.
- Sparse predicates, including one with only lane 7 set, together with upper predicate bits that carry junk. Reads issued out of order, or a lane that leaked upper bits, would show up in the request log or in the slices of the result.
- An error on lane 3. A design that committed the partly built segment would change vdst, and one that kept going would issue extra requests.
- A start that arrives while busy, and the zero-predicate timing. A design that restarted or queued the start, or took extra cycles to finish, would miss the expected done cycle.
- The 128-bit instance. It must finish with no traffic and no change to the destination.

// File: rtl/prl_pkg.sv
package prl_pkg;
    localparam int WORD_W     = 32;
    localparam int LANES      = 8;
    localparam int SEG_W      = WORD_W * LANES;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [LANES-1:0]      lane_mask_t;
    typedef logic [LANE_IDX_W-1:0] lane_idx_t;
    typedef word_t [LANES-1:0]     seg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        logic      any;
        lane_idx_t idx;
    } lane_pick_t;

    // Lowest-numbered set lane, so reads go out in ascending order.
    function automatic lane_pick_t first_lane(lane_mask_t m);
        lane_pick_t r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.any = 1'b1;
                r.idx = lane_idx_t'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/prl_addr_gen.sv
module prl_addr_gen
    import prl_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic [AW-1:0] base_addr,
    input  logic [IW-1:0] index,
    input  logic [AW-1:0] start_q,
    input  lane_idx_t     lane,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] lane_addr
);
    localparam int LANE_OFS_W = LANE_IDX_W + 2;

    logic [AW-1:0] idx_ext;
    logic [LANE_OFS_W-1:0] lane_ofs;

    assign idx_ext   = AW'(index);
    assign eff_addr  = base_addr + (idx_ext << 2);
    assign lane_ofs  = {lane, 2'b00};
    assign lane_addr = start_q + AW'(lane_ofs);
endmodule

// File: rtl/prl_seg_buf.sv
module prl_seg_buf
    import prl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      wr_en,
    input  lane_idx_t wr_lane,
    input  word_t     wr_data,
    output seg_t      seg
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                seg[g] <= '0;
            end else if (wr_en && (wr_lane == lane_idx_t'(g))) begin
                seg[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/prl_bcast.sv
module prl_bcast
    import prl_pkg::*;
#(
    parameter int VLEN = 512
) (
    input  seg_t            seg,
    output logic [VLEN-1:0] vec
);
    localparam int SLICES = VLEN / SEG_W;

    if (SLICES == 0) begin : g_narrow
        // Never committed: narrow widths are rejected before any load.
        assign vec = VLEN'(seg);
    end else begin : g_wide
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            assign vec[s*SEG_W +: SEG_W] = seg;
        end
        if (VLEN > SLICES * SEG_W) begin : g_tail
            assign vec[VLEN-1:SLICES*SEG_W] = '0;
        end
    end
endmodule

// File: rtl/seg_bcast_load.sv
module seg_bcast_load
    import prl_pkg::*;
#(
    parameter int VLEN = 512,
    parameter int AW   = 32,
    parameter int IW   = 32,
    localparam int PRED_W = (VLEN / WORD_W < LANES) ? LANES : VLEN / WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     base_addr,
    input  logic [IW-1:0]     index,
    input  logic [PRED_W-1:0] pred,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [AW-1:0]     req_addr,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    input  logic              rsp_err,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              fault,
    output logic [LANE_IDX_W-1:0] fault_lane,
    output logic [VLEN-1:0]   vdst
);
    localparam bit LEGAL = (VLEN >= SEG_W) && (VLEN % SEG_W == 0);

    state_e          st_q;
    lane_mask_t      pend_q;
    lane_idx_t       cur_q;
    logic [AW-1:0]   start_q;
    logic [AW-1:0]   eff_addr;
    lane_pick_t      pick;
    seg_t            seg;
    logic [VLEN-1:0] bcast_vec;
    logic            accept;
    logic            seg_wr;

    if (PRED_W > LANES) begin : g_pred_hi
        logic unused_pred_hi;
        assign unused_pred_hi = ^pred[PRED_W-1:LANES];
    end

    assign pick      = first_lane(pend_q);
    assign accept    = start && (st_q == ST_IDLE);
    assign seg_wr    = (st_q == ST_WAIT) && rsp_valid && !rsp_err;
    assign req_valid = (st_q == ST_ISSUE) && pick.any;
    assign busy      = (st_q != ST_IDLE);

    prl_addr_gen #(.AW(AW), .IW(IW)) u_addr (
        .base_addr (base_addr),
        .index     (index),
        .start_q   (start_q),
        .lane      (pick.idx),
        .eff_addr  (eff_addr),
        .lane_addr (req_addr)
    );

    prl_seg_buf u_seg (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .wr_en   (seg_wr),
        .wr_lane (cur_q),
        .wr_data (rsp_data),
        .seg     (seg)
    );

    prl_bcast #(.VLEN(VLEN)) u_bcast (
        .seg (seg),
        .vec (bcast_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            pend_q     <= '0;
            cur_q      <= '0;
            start_q    <= '0;
            done       <= 1'b0;
            illegal    <= 1'b0;
            fault      <= 1'b0;
            fault_lane <= '0;
            vdst       <= '0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        fault      <= 1'b0;
                        fault_lane <= '0;
                        if (!LEGAL) begin
                            illegal <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            illegal <= 1'b0;
                            pend_q  <= pred[LANES-1:0];
                            start_q <= eff_addr;
                            st_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (!pick.any) begin
                        vdst <= bcast_vec;
                        done <= 1'b1;
                        st_q <= ST_IDLE;
                    end else if (req_ready) begin
                        cur_q <= pick.idx;
                        st_q  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            fault      <= 1'b1;
                            fault_lane <= cur_q;
                            done       <= 1'b1;
                            pend_q     <= '0;
                            st_q       <= ST_IDLE;
                        end else begin
                            pend_q[cur_q] <= 1'b0;
                            st_q          <= ST_ISSUE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prl_chk.sv
module prl_chk #(
    parameter int VLEN = 512,
    parameter int AW   = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            fault,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [AW-1:0]   req_addr,
    input logic [VLEN-1:0] vdst
);
    logic [1:0] outst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_q + 2'((req_valid && req_ready) ? 1 : 0)
                               - 2'(rsp_valid ? 1 : 0);
        end
    end

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_single_out_r3: assert property (@(posedge clk) disable iff (rst)
        (outst_q != 2'd0) |-> !req_valid);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_vdst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done || $stable(vdst)));

    p_fault_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> done);

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !req_valid));
endmodule

bind seg_bcast_load prl_chk #(.VLEN(VLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .fault     (fault),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_addr  (req_addr),
    .vdst      (vdst)
);

// File: tb/tb_seg_bcast_load.sv
module tb_seg_bcast_load;
    localparam int CLK_PERIOD = 10;
    localparam int VL = 512;
    localparam int PW = VL / 32;
    localparam int NV = 6;

    localparam logic [31:0] T_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3FF0,
                                            32'h0000_0004, 32'hFFFF_FFF0, 32'h0000_0100};
    localparam logic [31:0] T_IDX  [NV] = '{32'd0, 32'd5, 32'hFFFF_FFFE, 32'd3, 32'd4, 32'd1};
    localparam logic [15:0] T_PRED [NV] = '{16'h00FF, 16'h0055, 16'hFF81,
                                            16'hF080, 16'h003C, 16'hA5A5};
    localparam logic [3:0]  T_RDY  [NV] = '{4'hF, 4'h5, 4'h9, 4'h3, 4'hE, 4'h7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          start = 1'b0;
    logic [31:0]   base_addr = '0;
    logic [31:0]   index = '0;
    logic [PW-1:0] pred = '0;
    logic          req_valid, req_ready;
    logic [31:0]   req_addr;
    logic          rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0]   rsp_data = '0;
    logic          busy, done, illegal, fault;
    logic [2:0]    fault_lane;
    logic [VL-1:0] vdst;

    seg_bcast_load #(.VLEN(VL)) dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .index(index),
        .pred(pred), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .busy(busy),
        .done(done), .illegal(illegal), .fault(fault), .fault_lane(fault_lane), .vdst(vdst)
    );

    // Narrow instance for the illegal-width case.
    logic          s_start = 1'b0;
    logic          s_req_valid, s_busy, s_done, s_illegal, s_fault;
    logic [31:0]   s_req_addr;
    logic [2:0]    s_fault_lane;
    logic [127:0]  s_vdst;
    int            s_req_seen = 0;

    seg_bcast_load #(.VLEN(128)) dut128 (
        .clk(clk), .rst(rst), .start(s_start), .base_addr(32'h40), .index(32'd2),
        .pred(8'hFF), .req_valid(s_req_valid), .req_ready(1'b1), .req_addr(s_req_addr),
        .rsp_valid(1'b0), .rsp_data(32'h0), .rsp_err(1'b0), .busy(s_busy),
        .done(s_done), .illegal(s_illegal), .fault(s_fault), .fault_lane(s_fault_lane),
        .vdst(s_vdst)
    );

    // Memory model
    logic [3:0]  rdy_pat = 4'hF;
    int          cyc = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] log_addr [0:255];
    int          log_n = 0;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    assign req_ready = rdy_pat[cyc[1:0]];

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        rsp_valid <= 1'b0;
        rsp_err   <= 1'b0;
        if (s_req_valid) s_req_seen <= s_req_seen + 1;
        if (!rst && req_valid && req_ready) begin
            if (log_n < 256) log_addr[log_n] <= req_addr;
            log_n     <= log_n + 1;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_word(req_addr);
            rsp_err   <= err_en && (req_addr == err_addr);
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [VL-1:0] exp_vec(logic [31:0] b, logic [31:0] i,
                                              logic [PW-1:0] p);
        logic [255:0]  s;
        logic [VL-1:0] r;
        s = '0;
        for (int k = 0; k < 8; k++)
            if (p[k]) s[k*32 +: 32] = mem_word(b + (i << 2) + 32'(4*k));
        for (int j = 0; j < VL/256; j++) r[j*256 +: 256] = s;
        return r;
    endfunction

    task automatic launch(input logic [31:0] b, input logic [31:0] i, input logic [PW-1:0] p);
        @(negedge clk);
        base_addr = b; index = i; pred = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic check_reqs(input int first, input logic [31:0] b, input logic [31:0] i,
                              input logic [PW-1:0] p, input int upto, input string tag);
        int j;
        j = 0;
        for (int k = 0; k < upto; k++) begin
            if (p[k]) begin
                chk(log_addr[first + j] == b + (i << 2) + 32'(4*k), tag,
                    VL'(log_addr[first + j]), VL'(b + (i << 2) + 32'(4*k)));
                j++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int first;
        logic [VL-1:0] prev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done && !req_valid, "R9 idle after reset", VL'({busy, done, req_valid}), '0);
        chk(!fault && !illegal, "R9 flags low after reset", VL'({fault, illegal}), '0);
        chk(vdst == '0, "R9 vdst zero after reset", vdst, '0);

        // Table of vectors: R1 R2 R3 R4 R8
        for (int v = 0; v < NV; v++) begin
            rdy_pat = T_RDY[v];
            first = log_n;
            launch(T_BASE[v], T_IDX[v], T_PRED[v]);
            wait_done(seen);
            chk(seen, "R8 done seen", VL'(seen), VL'(1));
            chk(vdst == exp_vec(T_BASE[v], T_IDX[v], T_PRED[v]), "R4 R2 broadcast segment",
                vdst, exp_vec(T_BASE[v], T_IDX[v], T_PRED[v]));
            chk(log_n - first == $countones(T_PRED[v][7:0]), "R2 request count",
                VL'(log_n - first), VL'($countones(T_PRED[v][7:0])));
            check_reqs(first, T_BASE[v], T_IDX[v], T_PRED[v], 8, "R1 R3 address order");
            chk(!fault && !illegal, "R6 no fault on clean op", VL'({fault, illegal}), '0);
            @(negedge clk);
            chk(!done, "R8 done one cycle", VL'(done), '0);
        end

        // R5 all-zero predicate with upper junk
        rdy_pat = 4'hF;
        first = log_n;
        launch(32'h5000, 32'd7, 16'hFF00);
        chk(!done && busy, "R5 not done first cycle", VL'({done, busy}), VL'(2'b01));
        @(negedge clk);
        chk(done, "R5 done second cycle", VL'(done), VL'(1));
        chk(vdst == '0, "R5 vdst zero", vdst, '0);
        chk(log_n == first, "R5 no requests", VL'(log_n - first), '0);

        // Known nonzero destination before fault
        launch(32'h6000, 32'd0, 16'h00FF);
        wait_done(seen);
        prev = vdst;
        @(negedge clk);

        // R6 error on lane 3
        err_en = 1'b1; err_addr = 32'h7000 + 32'd12;
        first = log_n;
        launch(32'h7000, 32'd0, 16'h00FF);
        wait_done(seen);
        chk(fault && fault_lane == 3'd3, "R6 fault lane", VL'({fault, fault_lane}), VL'(4'hB));
        chk(vdst == prev, "R6 vdst unchanged", vdst, prev);
        chk(log_n - first == 4, "R6 requests stop", VL'(log_n - first), VL'(4));
        err_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(fault && log_n - first == 4, "R10 R6 fault held, no traffic",
            VL'({fault, 8'(log_n - first)}), VL'({1'b1, 8'd4}));

        // R10 next start clears fault
        launch(32'h8000, 32'd1, 16'h0003);
        wait_done(seen);
        chk(!fault, "R10 fault cleared", VL'(fault), '0);
        chk(vdst == exp_vec(32'h8000, 32'd1, 16'h0003), "R4 after clear",
            vdst, exp_vec(32'h8000, 32'd1, 16'h0003));
        @(negedge clk);

        // R8 start while busy is ignored
        rdy_pat = 4'h1;
        first = log_n;
        launch(32'h9000, 32'd2, 16'h00FF);
        repeat (3) @(negedge clk);
        chk(busy, "R8 still busy", VL'(busy), VL'(1));
        base_addr = 32'hA000; pred = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(vdst == exp_vec(32'h9000, 32'd2, 16'h00FF), "R8 busy start ignored",
            vdst, exp_vec(32'h9000, 32'd2, 16'h00FF));
        chk(log_n - first == 8, "R8 request count", VL'(log_n - first), VL'(8));
        check_reqs(first, 32'h9000, 32'd2, 16'h00FF, 8, "R8 R3 addresses");
        repeat (4) @(negedge clk);
        chk(!busy && !done && log_n - first == 8, "R8 no late restart",
            VL'({busy, done}), '0);

        // R7 narrow width
        @(negedge clk);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk(s_illegal && s_done && !s_busy, "R7 illegal and done",
            VL'({s_illegal, s_done, s_busy}), VL'(3'b110));
        chk(s_vdst == '0, "R7 vdst unchanged", VL'(s_vdst), '0);
        repeat (3) @(negedge clk);
        chk(s_illegal && !s_done && s_req_seen == 0, "R7 R10 illegal held, no traffic",
            VL'({s_illegal, s_done, 8'(s_req_seen)}), VL'({2'b10, 8'd0}));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule